// File: doc/BRIEF.md
# Address-Generation Interlock Detector

This block sits between decode and address generation in a dual-issue, in-order integer pipeline. Each cycle it looks at the instruction pair that is about to form its addresses. It compares the registers that pair needs against the registers written by the pair now in execution, which is the pair that left address generation one cycle earlier. If an address would depend on a result that is not yet available, it raises a one-cycle stall request for the whole pair and reports why.

Explicit memory operands and load-effective-address instructions check their base and index registers. Push, pop, call and return check the stack pointer implicitly. The block also keeps a small history of the stack-pointer writes made by push, pop, call and plain return. Such a write never causes a stall, because a predictor already knows the new stack pointer value. An ordinary arithmetic or move write to the stack pointer does stall the next stack access, and so does a return that adds an immediate.

The writer history is one cycle deep. It is loaded only when a pair actually advances. When the pair is stalled, or when no pair issues, the history becomes empty, because only a bubble moves into execution. The retried pair therefore goes through after exactly one stall cycle.

Top module: `agi_interlock`

## Requirements
- R1: A slot of class MEM (code 1) whose valid base register or valid index register equals a register written by an ordinary writer (kind 0) in the previous advancing cycle raises `stall` with `reason` 2'b01.
- R2: A slot of class LEA (code 2) is checked on its base and index registers exactly as in R1, with the same stall and reason 2'b01.
- R3: A stall lasts one cycle. The same pair presented again in the next cycle does not stall, because the bubble records no writers.
- R4: A write made two or more cycles before the dependent pair causes no stall.
- R5: A slot of class PUSH (3), POP (4), CALL (5) or RET (6) stalls with reason 2'b10 when the stack pointer (register index 4) was written in the previous cycle by an ordinary writer (kind 0).
- R6: A stack-pointer write of kind STACK (1), which covers push, pop, call and plain return, never causes a stall. This holds for implicit stack users and for an explicit base or index equal to register 4.
- R7: A stack-pointer write of kind RETIMM (2) stalls the next implicit stack user, and any explicit base or index equal to register 4, with reason 2'b11.
- R8: A hazard in either slot stalls the whole pair. When both slots have hazards, the reported reason is the larger code, in the priority 11 > 10 > 01.
- R9: No stall is raised for class ALU (0), for a slot whose valid bit is low, or when `issue_valid` is low. A cycle with `issue_valid` low also leaves the history empty.
- R10: While `rst_n` is low and right after reset, the history is empty, so `stall` is 0 and `reason` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| issue_valid | input | 1 | A pair is presented to address generation this cycle |
| slot_vld | input | ISSUE | Per-slot instruction valid |
| slot_cls | input | ISSUE x 3 | Per-slot class: 0 ALU, 1 MEM, 2 LEA, 3 PUSH, 4 POP, 5 CALL, 6 RET |
| slot_base | input | ISSUE x REG_W | Base register index |
| slot_base_vld | input | ISSUE | Base register is used |
| slot_idx | input | ISSUE x REG_W | Index register index |
| slot_idx_vld | input | ISSUE | Index register is used |
| slot_wen | input | ISSUE | Slot writes a register |
| slot_wreg | input | ISSUE x REG_W | Destination register index |
| slot_wkind | input | ISSUE x 2 | Writer kind: 0 ordinary, 1 stack update, 2 return with immediate |
| stall | output | 1 | Hold the pair for one cycle |
| reason | output | 2 | 00 none, 01 base/index, 10 implicit stack pointer, 11 return-immediate |

## Verification
The assertions assume that a stalled pair is presented again in the next cycle, and that writer kinds STACK and RETIMM are only ever given with register 4 as the destination. The bench follows these rules. Its directed cycles always replay a stalled pair. Its random phase repeats the previous inputs whenever the model predicts a stall, and it draws kind 1 or 2 only together with register 4.

// File: rtl/agi_pkg.sv
package agi_pkg;
  typedef enum logic [2:0] {
    CLS_ALU  = 3'd0,
    CLS_MEM  = 3'd1,
    CLS_LEA  = 3'd2,
    CLS_PUSH = 3'd3,
    CLS_POP  = 3'd4,
    CLS_CALL = 3'd5,
    CLS_RET  = 3'd6
  } cls_e;

  typedef enum logic [1:0] {
    WK_ORD    = 2'd0,
    WK_STACK  = 2'd1,
    WK_RETIMM = 2'd2
  } wkind_e;

  localparam logic [1:0] RSN_NONE = 2'b00;
  localparam logic [1:0] RSN_EXPL = 2'b01;
  localparam logic [1:0] RSN_IMPL = 2'b10;
  localparam logic [1:0] RSN_RETI = 2'b11;
endpackage

// File: rtl/agi_hist.sv
module agi_hist #(
  parameter int ISSUE = 2,
  parameter int REG_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        advance,
  input  logic [ISSUE-1:0]            wr_en,
  input  logic [ISSUE-1:0][REG_W-1:0] wr_reg,
  input  logic [ISSUE-1:0][1:0]       wr_kind,
  output logic [ISSUE-1:0]            h_vld,
  output logic [ISSUE-1:0][REG_W-1:0] h_reg,
  output logic [ISSUE-1:0][1:0]       h_kind
);
  logic [ISSUE-1:0]            vld_n;
  logic [ISSUE-1:0][REG_W-1:0] reg_n;
  logic [ISSUE-1:0][1:0]       kind_n;

  always_comb begin
    for (int k = 0; k < ISSUE; k++) begin
      vld_n[k]  = advance & wr_en[k];
      reg_n[k]  = advance ? wr_reg[k]  : h_reg[k];
      kind_n[k] = advance ? wr_kind[k] : h_kind[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_vld  <= '0;
      h_reg  <= '0;
      h_kind <= '0;
    end else begin
      h_vld  <= vld_n;
      h_reg  <= reg_n;
      h_kind <= kind_n;
    end
  end

  AST_BUBBLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> (h_vld == '0)) else $error("bubble left writers"); // R3
endmodule

// File: rtl/agi_slot_chk.sv
module agi_slot_chk
  import agi_pkg::*;
#(
  parameter int ISSUE  = 2,
  parameter int REG_W  = 3,
  parameter int SP_IDX = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        act,
  input  logic [2:0]                  cls,
  input  logic [REG_W-1:0]            base,
  input  logic                        base_vld,
  input  logic [REG_W-1:0]            idx,
  input  logic                        idx_vld,
  input  logic [ISSUE-1:0]            h_vld,
  input  logic [ISSUE-1:0][REG_W-1:0] h_reg,
  input  logic [ISSUE-1:0][1:0]       h_kind,
  output logic [1:0]                  code
);
  localparam logic [REG_W-1:0] SP = REG_W'(SP_IDX);

  cls_e cls_t;
  logic explicit_use;
  logic implicit_use;
  logic sp_stack_only;

  assign cls_t        = cls_e'(cls);
  assign explicit_use = act && (cls_t == CLS_MEM || cls_t == CLS_LEA);
  assign implicit_use = act && (cls_t == CLS_PUSH || cls_t == CLS_POP ||
                                cls_t == CLS_CALL || cls_t == CLS_RET);

  function automatic logic [1:0] hit_code(input logic [REG_W-1:0] r, input logic is_impl,
                                          input logic [ISSUE-1:0] v,
                                          input logic [ISSUE-1:0][REG_W-1:0] hr,
                                          input logic [ISSUE-1:0][1:0] hk);
    logic [1:0] c;
    c = RSN_NONE;
    for (int k = 0; k < ISSUE; k++) begin
      if (v[k] && hr[k] == r && wkind_e'(hk[k]) != WK_STACK) begin
        if (r == SP && wkind_e'(hk[k]) == WK_RETIMM) c = RSN_RETI;
        else if (is_impl && c != RSN_RETI)            c = RSN_IMPL;
        else if (c == RSN_NONE)                        c = RSN_EXPL;
      end
    end
    return c;
  endfunction

  logic [1:0] c_base, c_idx, c_sp;

  always_comb begin
    c_base = (explicit_use && base_vld) ? hit_code(base, 1'b0, h_vld, h_reg, h_kind) : RSN_NONE;
    c_idx  = (explicit_use && idx_vld)  ? hit_code(idx,  1'b0, h_vld, h_reg, h_kind) : RSN_NONE;
    c_sp   = implicit_use               ? hit_code(SP,   1'b1, h_vld, h_reg, h_kind) : RSN_NONE;
    code   = c_base;
    if (c_idx > code) code = c_idx;
    if (c_sp  > code) code = c_sp;
  end

  always_comb begin
    sp_stack_only = 1'b1;
    for (int k = 0; k < ISSUE; k++)
      if (h_vld[k] && wkind_e'(h_kind[k]) != WK_STACK) sp_stack_only = 1'b0;
  end

  AST_STACK_EXEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    sp_stack_only |-> code == RSN_NONE) else $error("stack-kind write stalled"); // R6
  AST_ALU_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!act || cls_t == CLS_ALU) |-> code == RSN_NONE) else $error("inactive slot flagged"); // R9
endmodule

// File: rtl/agi_interlock.sv
module agi_interlock
  import agi_pkg::*;
#(
  parameter int ISSUE  = 2,
  parameter int REG_W  = 3,
  parameter int SP_IDX = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        issue_valid,
  input  logic [ISSUE-1:0]            slot_vld,
  input  logic [ISSUE-1:0][2:0]       slot_cls,
  input  logic [ISSUE-1:0][REG_W-1:0] slot_base,
  input  logic [ISSUE-1:0]            slot_base_vld,
  input  logic [ISSUE-1:0][REG_W-1:0] slot_idx,
  input  logic [ISSUE-1:0]            slot_idx_vld,
  input  logic [ISSUE-1:0]            slot_wen,
  input  logic [ISSUE-1:0][REG_W-1:0] slot_wreg,
  input  logic [ISSUE-1:0][1:0]       slot_wkind,
  output logic                        stall,
  output logic [1:0]                  reason
);
  logic [ISSUE-1:0]            h_vld;
  logic [ISSUE-1:0][REG_W-1:0] h_reg;
  logic [ISSUE-1:0][1:0]       h_kind;
  logic [ISSUE-1:0][1:0]       codes;
  logic [ISSUE-1:0]            hits;
  logic                        advance;
  logic [ISSUE-1:0]            wr_en;

  assign advance = issue_valid & ~stall;
  assign wr_en   = slot_vld & slot_wen;

  agi_hist #(.ISSUE(ISSUE), .REG_W(REG_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .advance(advance),
    .wr_en(wr_en), .wr_reg(slot_wreg), .wr_kind(slot_wkind),
    .h_vld(h_vld), .h_reg(h_reg), .h_kind(h_kind)
  );

  for (genvar s = 0; s < ISSUE; s++) begin : g_slot
    agi_slot_chk #(.ISSUE(ISSUE), .REG_W(REG_W), .SP_IDX(SP_IDX)) u_chk (
      .clk(clk), .rst_n(rst_n),
      .act(issue_valid & slot_vld[s]),
      .cls(slot_cls[s]),
      .base(slot_base[s]), .base_vld(slot_base_vld[s]),
      .idx(slot_idx[s]),   .idx_vld(slot_idx_vld[s]),
      .h_vld(h_vld), .h_reg(h_reg), .h_kind(h_kind),
      .code(codes[s])
    );
    assign hits[s] = |codes[s];
  end

  always_comb begin
    reason = RSN_NONE;
    for (int s = 0; s < ISSUE; s++)
      if (codes[s] > reason) reason = codes[s];
  end

  assign stall = |hits;

  AST_ONE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall) else $error("stall longer than one cycle"); // R3
  AST_CODE_WITH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> reason != RSN_NONE) else $error("stall without reason"); // R8
  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> !stall) else $error("stall with no pair"); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !stall && reason == RSN_NONE) else $error("stall in reset"); // R10
endmodule

// File: tb/agi_interlock_test.sv
module agi_interlock_test;
  localparam int ISSUE = 2;
  localparam int REG_W = 3;
  localparam int SP = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic issue_valid;
  logic [ISSUE-1:0]            slot_vld, slot_base_vld, slot_idx_vld, slot_wen;
  logic [ISSUE-1:0][2:0]       slot_cls;
  logic [ISSUE-1:0][REG_W-1:0] slot_base, slot_idx, slot_wreg;
  logic [ISSUE-1:0][1:0]       slot_wkind;
  logic stall;
  logic [1:0] reason;

  int total = 0;
  int bad = 0;

  // behavioural model state: writers from the previous advancing cycle
  int m_vld[2];
  int m_reg[2];
  int m_kind[2];
  int exp_reason;

  always #10 clk = ~clk;

  agi_interlock #(.ISSUE(ISSUE), .REG_W(REG_W), .SP_IDX(SP)) uut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
    .slot_vld(slot_vld), .slot_cls(slot_cls),
    .slot_base(slot_base), .slot_base_vld(slot_base_vld),
    .slot_idx(slot_idx), .slot_idx_vld(slot_idx_vld),
    .slot_wen(slot_wen), .slot_wreg(slot_wreg), .slot_wkind(slot_wkind),
    .stall(stall), .reason(reason)
  );

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic int reg_code(int r, int impl);
    int c = 0;
    for (int k = 0; k < 2; k++)
      if (m_vld[k] != 0 && m_reg[k] == r && m_kind[k] != 1) begin
        if (r == SP && m_kind[k] == 2) c = 3;
        else if (impl != 0 && c < 2) c = 2;
        else if (c < 1) c = 1;
      end
    return c;
  endfunction

  function automatic int model_reason();
    int best = 0;
    int c;
    if (!issue_valid) return 0;
    for (int s = 0; s < 2; s++) begin
      if (!slot_vld[s]) continue;
      c = 0;
      if (slot_cls[s] == 3'd1 || slot_cls[s] == 3'd2) begin
        if (slot_base_vld[s]) c = reg_code(int'(slot_base[s]), 0);
        if (slot_idx_vld[s] && reg_code(int'(slot_idx[s]), 0) > c) c = reg_code(int'(slot_idx[s]), 0);
      end else if (slot_cls[s] >= 3'd3 && slot_cls[s] <= 3'd6) begin
        c = reg_code(SP, 1);
      end
      if (c > best) best = c;
    end
    return best;
  endfunction

  task automatic clear_slots();
    issue_valid = 1'b1;
    slot_vld = '0; slot_cls = '0; slot_base = '0; slot_base_vld = '0;
    slot_idx = '0; slot_idx_vld = '0; slot_wen = '0; slot_wreg = '0; slot_wkind = '0;
  endtask

  task automatic set_slot(int s, int cls, int b, int bv, int ix, int iv, int we, int wr, int wk);
    slot_vld[s] = 1'b1;
    slot_cls[s] = 3'(cls);
    slot_base[s] = REG_W'(b);     slot_base_vld[s] = bv[0];
    slot_idx[s] = REG_W'(ix);     slot_idx_vld[s] = iv[0];
    slot_wen[s] = we[0];          slot_wreg[s] = REG_W'(wr);
    slot_wkind[s] = 2'(wk);
  endtask

  // inputs already set at a falling edge; check, then step across the rising edge
  task automatic cyc(string tag, int want);
    exp_reason = model_reason();
    #1;
    total++;
    if (want >= 0 && want != exp_reason)
      $display("note %s: model gives %0d, scenario intended %0d", tag, exp_reason, want);
    if (stall !== (exp_reason != 0) || reason !== 2'(exp_reason)) begin
      bad++;
      $display("FAIL %s: actual stall=%0b reason=%0d expected stall=%0b reason=%0d",
               tag, stall, reason, exp_reason != 0, exp_reason);
    end
    @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      if (issue_valid && exp_reason == 0 && slot_vld[k] && slot_wen[k]) begin
        m_vld[k] = 1; m_reg[k] = int'(slot_wreg[k]); m_kind[k] = int'(slot_wkind[k]);
      end else m_vld[k] = 0;
    end
    @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin m_vld[k] = 0; m_reg[k] = 0; m_kind[k] = 0; end
    rst_n = 1'b0;
    clear_slots();
    set_slot(0, 1, 1, 1, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    total++;
    if (stall !== 1'b0 || reason !== 2'b00) begin
      bad++; $display("FAIL R10: in reset actual stall=%0b reason=%0d expected 0 0", stall, reason);
    end
    rst_n = 1'b1;
    @(negedge clk);
    cyc("R10 after reset", 0);

    // R1 base hazard, R3 single bubble
    clear_slots(); set_slot(0, 0, 0, 0, 0, 0, 1, 3, 0); cyc("R1 producer", 0);
    clear_slots(); set_slot(0, 1, 3, 1, 0, 0, 0, 0, 0); cyc("R1 base hit", 1);
    cyc("R3 retry passes", 0);
    // R1 index hazard
    clear_slots(); set_slot(1, 0, 0, 0, 0, 0, 1, 6, 0); cyc("R1 producer2", 0);
    clear_slots(); set_slot(0, 1, 0, 1, 6, 1, 0, 0, 0); cyc("R1 index hit", 1);
    cyc("R3 retry idx", 0);
    // R4 two cycles back
    clear_slots(); set_slot(0, 0, 0, 0, 0, 0, 1, 5, 0); cyc("R4 producer", 0);
    clear_slots(); set_slot(0, 0, 0, 0, 0, 0, 0, 0, 0); cyc("R4 filler", 0);
    clear_slots(); set_slot(0, 1, 5, 1, 5, 1, 0, 0, 0); cyc("R4 stale dep", 0);
    // R2 LEA
    clear_slots(); set_slot(0, 0, 0, 0, 0, 0, 1, 2, 0); cyc("R2 producer", 0);
    clear_slots(); set_slot(0, 2, 7, 1, 2, 1, 0, 0, 0); cyc("R2 lea hit", 1);
    cyc("R3 lea retry", 0);
    // R5 ordinary SP write then push / ret
    clear_slots(); set_slot(0, 0, 0, 0, 0, 0, 1, SP, 0); cyc("R5 sp add", 0);
    clear_slots(); set_slot(0, 3, 0, 0, 0, 0, 1, SP, 1); cyc("R5 push stalls", 2);
    cyc("R3 push retry", 0);
    clear_slots(); set_slot(0, 0, 0, 0, 0, 0, 1, SP, 0); cyc("R5 sp move", 0);
    clear_slots(); set_slot(0, 6, 0, 0, 0, 0, 1, SP, 1); cyc("R5 ret stalls", 2);
    cyc("R5 ret retry", 0);
    // R6 stack-kind writes exempt
    clear_slots(); set_slot(0, 4, 0, 0, 0, 0, 1, SP, 1); cyc("R6 pop", 0);
    clear_slots(); set_slot(0, 4, 0, 0, 0, 0, 1, SP, 1); cyc("R6 pop after pop", 0);
    clear_slots(); set_slot(0, 5, 0, 0, 0, 0, 1, SP, 1); cyc("R6 call after pop", 0);
    clear_slots(); set_slot(0, 1, SP, 1, 0, 0, 0, 0, 0); cyc("R6 explicit sp after call", 0);
    // R7 return with immediate
    clear_slots(); set_slot(0, 6, 0, 0, 0, 0, 1, SP, 2); cyc("R7 ret imm", 0);
    clear_slots(); set_slot(0, 4, 0, 0, 0, 0, 1, SP, 1); cyc("R7 pop after ret imm", 3);
    cyc("R7 retry", 0);
    clear_slots(); set_slot(0, 6, 0, 0, 0, 0, 1, SP, 2); cyc("R7 ret imm2", 0);
    clear_slots(); set_slot(1, 1, 0, 0, SP, 1, 0, 0, 0); cyc("R7 explicit sp idx", 3);
    cyc("R7 retry2", 0);
    // R8 pair behaviour
    clear_slots(); set_slot(0, 0, 0, 0, 0, 0, 1, 1, 0); set_slot(1, 0, 0, 0, 0, 0, 1, SP, 0); cyc("R8 producers", 0);
    clear_slots(); set_slot(0, 1, 1, 1, 0, 0, 0, 0, 0); set_slot(1, 3, 0, 0, 0, 0, 1, SP, 1); cyc("R8 priority", 2);
    cyc("R8 retry", 0);
    clear_slots(); set_slot(0, 0, 0, 0, 0, 0, 1, 1, 0); cyc("R8 producer slot0", 0);
    clear_slots(); set_slot(0, 0, 0, 0, 0, 0, 0, 0, 0); set_slot(1, 1, 1, 1, 0, 0, 0, 0, 0); cyc("R8 slot1 only", 1);
    cyc("R8 retry2", 0);
    // R9 ignored cases
    clear_slots(); set_slot(0, 0, 0, 0, 0, 0, 1, 3, 0); cyc("R9 producer", 0);
    clear_slots(); set_slot(0, 0, 3, 1, 3, 1, 1, 3, 0); cyc("R9 alu fields ignored", 0);
    clear_slots(); set_slot(0, 1, 3, 1, 0, 0, 0, 0, 0); slot_vld[0] = 1'b0; cyc("R9 invalid slot", 0);
    clear_slots(); set_slot(0, 0, 0, 0, 0, 0, 1, 2, 0); cyc("R9 producer2", 0);
    clear_slots(); issue_valid = 1'b0; set_slot(0, 1, 2, 1, 0, 0, 1, 2, 0); cyc("R9 no issue", 0);
    clear_slots(); set_slot(0, 1, 2, 1, 0, 0, 0, 0, 0); cyc("R9 history empty after idle", 0);

    // random phase; stalled pairs are replayed, kinds 1/2 only with SP
    clear_slots();
    for (int n = 0; n < 600; n++) begin
      string tag;
      if (exp_reason == 0) begin
        clear_slots();
        issue_valid = ($urandom_range(0, 7) != 0);
        for (int s = 0; s < 2; s++) begin
          int wk = $urandom_range(0, 2);
          int wr = (wk == 0) ? $urandom_range(0, 7) : SP;
          set_slot(s, $urandom_range(0, 6), $urandom_range(0, 7), $urandom_range(0, 1),
                   $urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 1), wr, wk);
          slot_vld[s] = ($urandom_range(0, 5) != 0);
        end
      end
      exp_reason = model_reason();
      case (exp_reason)
        1: tag = "R1 random";
        2: tag = "R5 random";
        3: tag = "R7 random";
        default: tag = "R9 random";
      endcase
      cyc(tag, -1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule